// File: doc/BRIEF.md
# Read-coherent dual-copy clock register transfer

This block holds two copies of eight timekeeping bytes. The working copy advances on every update tick. An external counter chain supplies the incremented values, and that arithmetic is outside the block. The user copy is what the bus reads. On a tick, the user copy takes all eight freshly incremented bytes at one clock edge, so a reader never sees a mix of old and new fields.

The user copy is held still while the bus is reading within the clock range (addresses 00h to 07h), so a byte or a burst read stays coherent. It is also held while a halt bit is set, and a power-fail input sets that bit. A tick that arrives while the copy is held is remembered. One catch-up transfer then loads the user copy from the working copy on the first cycle after the hold ends. The hold ends on a bus stop, when the pointer moves past 07h, or when software clears the halt bit.

The bus front end keeps an auto-incrementing pointer over sixteen byte locations. Locations 08h to 0Fh are plain storage bytes. Bit 6 of location 0Ch is the halt bit.

Top module: `rtc_xfer_top`

## Requirements
- R1: After reset the pointer is 00h, both copies of all eight clock bytes are zero and the halt bit is 0.
- R2: A tick with no hold in force loads the working copy and the user copy with `int_inc_i` at the same clock edge, for all eight bytes.
- R3: A read strobe at a pointer in 00h..07h holds the user copy from that cycle on, for as long as the pointer stays in 00h..07h and no stop arrives.
- R4: The read hold ends when `stop_i` is seen or when the pointer increments to 08h or above. Reads at 08h..0Fh never hold the user copy.
- R5: A tick that arrives during a hold sets a pending flag. Exactly one transfer, from the working copy, happens on the first cycle after the hold ends, so the user copy then equals the working copy.
- R6: A high `pfail_i` sets the halt bit (bit 6 of the byte at 0Ch). While that bit is 1 the user copy does not follow ticks. Writing the bit to 0 lets the pending transfer happen on the next cycle.
- R7: If `pfail_i` and a bus write that clears the halt bit fall in the same cycle, the halt bit ends up as 1.
- R8: A bus write to 00h..07h loads that byte in both copies at the same edge, even during a hold. For that byte, the write wins over a tick in the same cycle.
- R9: Each read or write strobe increments the pointer, wrapping from 0Fh to 00h. `ptr_load_i` loads the pointer from `ptr_addr_i`.
- R10: `rd_data_o` shows the user-copy byte for 00h..07h and the stored byte for 08h..0Fh. At 0Ch, bit 6 is replaced by the halt bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Bus start condition pulse |
| stop_i | input | 1 | Bus stop condition pulse |
| ptr_load_i | input | 1 | Load the pointer from ptr_addr_i |
| ptr_addr_i | input | 4 | Pointer load value |
| wr_i | input | 1 | Write strobe; writes wr_data_i at the pointer, then increments it |
| wr_data_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe; the byte at the pointer is consumed, then the pointer increments |
| rd_data_o | output | 8 | Byte at the current pointer |
| ptr_o | output | 4 | Current pointer |
| tick_i | input | 1 | Update tick from the counter chain |
| pfail_i | input | 1 | Power-fail indication |
| int_inc_i | input | 64 | Incremented working-copy values, byte i at bits 8i+7..8i |
| int_o | output | 64 | Working copy, byte i at bits 8i+7..8i |
| ext_o | output | 64 | User copy, byte i at bits 8i+7..8i |
| halt_o | output | 1 | Halt bit |

## Verification
Three things can collide with a tick in one cycle: a read strobe that starts a hold, a bus write to a clock byte, and a power-fail that meets a write clearing the halt bit. The bench sweeps the read start over all sixteen addresses with a tick in the same cycle. For each start it judges whether the user copy moved, using the address range, and when the catch-up transfer lands. It also drives a clock-byte write together with a tick inside a hold, and a power-fail together with a halt-clearing write. It checks which value wins against an arithmetic model of the working copy.

// File: rtl/rtc_xfer_pkg.sv
`timescale 1ns/1ps
package rtc_xfer_pkg;
  typedef struct packed {
    logic start;
    logic stop;
    logic rd;
    logic wr;
  } bus_ev_t;
endpackage

// File: rtl/rtc_xfer_ptr.sv
`timescale 1ns/1ps
module rtc_xfer_ptr
  import rtc_xfer_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int NUM_CLK  = 8,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bus_ev_t       ev_i,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_addr_i,
  output logic [AW-1:0] ptr_o,
  output logic          in_clk_o,
  output logic          freeze_o
);
  localparam logic [AW-1:0] LAST = AW'(NUM_REGS - 1);
  localparam logic [AW-1:0] CLK_END = AW'(NUM_CLK);

  logic [AW-1:0] ptr_q;
  logic          rd_act_q;
  logic          step;

  assign step = ev_i.rd | ev_i.wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (ld_i) begin
      ptr_q <= ld_addr_i;
    end else if (step) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  // read phase: set by a read, dropped by stop or a new start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rd_act_q <= 1'b0;
    else if (ev_i.stop) rd_act_q <= 1'b0;
    else if (ev_i.rd)   rd_act_q <= 1'b1;
    else if (ev_i.start) rd_act_q <= 1'b0;
  end

  assign in_clk_o = (ptr_q < CLK_END);
  // the strobe cycle itself is held so the first byte matches the rest
  assign freeze_o = in_clk_o & (rd_act_q | ev_i.rd);
  assign ptr_o    = ptr_q;

  // R9
  ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !ld_i && ptr_q == LAST) |=> (ptr_q == '0));

  // R9
  ptr_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !ld_i && ptr_q != LAST) |=> (ptr_q == $past(ptr_q) + 1'b1));

  // R4
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i.stop && !ev_i.rd) |=> !freeze_o || ev_i.rd);
endmodule

// File: rtl/rtc_xfer_gate.sv
`timescale 1ns/1ps
module rtc_xfer_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic freeze_i,
  input  logic pfail_i,
  input  logic halt_wr_i,
  input  logic halt_wd_i,
  output logic halt_o,
  output logic xfer_o,
  output logic xfer_live_o
);
  logic halt_q;
  logic pend_q;
  logic blocked;

  assign blocked = freeze_i | halt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        halt_q <= 1'b0;
    else if (pfail_i)   halt_q <= 1'b1;
    else if (halt_wr_i) halt_q <= halt_wd_i;
  end

  assign xfer_o      = (tick_i | pend_q) & ~blocked;
  assign xfer_live_o = tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pend_q <= 1'b0;
    else if (tick_i && blocked)  pend_q <= 1'b1;
    else if (xfer_o)             pend_q <= 1'b0;
  end

  assign halt_o = halt_q;

  // R7
  pfail_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfail_i |=> halt_q);

  // R5
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && blocked) |=> pend_q);

  // R5
  pend_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |=> !pend_q);

  // R6
  halt_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(halt_q) && halt_q) |-> !xfer_o);
endmodule

// File: rtl/rtc_xfer_bank.sv
`timescale 1ns/1ps
module rtc_xfer_bank #(
  parameter int NUM_REGS = 16,
  parameter int NUM_CLK  = 8,
  parameter int DW       = 8,
  localparam int AW   = $clog2(NUM_REGS),
  localparam int CW   = NUM_CLK * DW,
  localparam int NAUX = NUM_REGS - NUM_CLK
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [CW-1:0] inc_i,
  input  logic          xfer_i,
  input  logic          xfer_live_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_byte_o,
  output logic [CW-1:0] int_o,
  output logic [CW-1:0] ext_o
);
  logic [DW-1:0] all_regs [NUM_REGS];
  logic          clk_wr;

  assign clk_wr = wr_i & (addr_i < AW'(NUM_CLK));

  for (genvar i = 0; i < NUM_CLK; i++) begin : g_clk
    logic [DW-1:0] int_q, ext_q, inc_b;
    logic          hit;
    assign inc_b = inc_i[i*DW +: DW];
    assign hit   = wr_i & (addr_i == AW'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     int_q <= '0;
      else if (hit)    int_q <= wr_data_i;
      else if (tick_i) int_q <= inc_b;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ext_q <= '0;
      else if (hit)    ext_q <= wr_data_i;
      else if (xfer_i) ext_q <= xfer_live_i ? inc_b : int_q;
    end

    assign int_o[i*DW +: DW] = int_q;
    assign ext_o[i*DW +: DW] = ext_q;
    assign all_regs[i]       = ext_q;

    // R8
    wr_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit |=> (int_q == ext_q) && (ext_q == $past(wr_data_i)));
  end

  for (genvar j = 0; j < NAUX; j++) begin : g_aux
    logic [DW-1:0] aux_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) aux_q <= '0;
      else if (wr_i && addr_i == AW'(NUM_CLK + j)) aux_q <= wr_data_i;
    end
    assign all_regs[NUM_CLK + j] = aux_q;
  end

  assign rd_byte_o = all_regs[addr_i];

  // R3
  ext_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_i && !clk_wr) |=> $stable(ext_o));

  // R2
  xfer_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && !clk_wr) |=> (ext_o == int_o));
endmodule

// File: rtl/rtc_xfer_top.sv
`timescale 1ns/1ps
module rtc_xfer_top
  import rtc_xfer_pkg::*;
#(
  parameter int NUM_CLK   = 8,
  parameter int NUM_REGS  = 16,
  parameter int DW        = 8,
  parameter int HALT_ADDR = 12,
  parameter int HALT_BIT  = 6,
  localparam int AW = $clog2(NUM_REGS),
  localparam int CW = NUM_CLK * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          ptr_load_i,
  input  logic [AW-1:0] ptr_addr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_i,
  output logic [DW-1:0] rd_data_o,
  output logic [AW-1:0] ptr_o,
  input  logic          tick_i,
  input  logic          pfail_i,
  input  logic [CW-1:0] int_inc_i,
  output logic [CW-1:0] int_o,
  output logic [CW-1:0] ext_o,
  output logic          halt_o
);
  bus_ev_t       ev;
  logic [AW-1:0] ptr;
  logic          in_clk, freeze;
  logic          halt, xfer, xfer_live, halt_wr;
  logic [DW-1:0] rd_byte;

  assign ev = '{start: start_i, stop: stop_i, rd: rd_i, wr: wr_i};

  rtc_xfer_ptr #(.NUM_REGS(NUM_REGS), .NUM_CLK(NUM_CLK)) u_ptr (
    .clk_i, .rst_ni, .ev_i(ev), .ld_i(ptr_load_i), .ld_addr_i(ptr_addr_i),
    .ptr_o(ptr), .in_clk_o(in_clk), .freeze_o(freeze)
  );

  assign halt_wr = wr_i & (ptr == AW'(HALT_ADDR));

  rtc_xfer_gate u_gate (
    .clk_i, .rst_ni, .tick_i, .freeze_i(freeze), .pfail_i,
    .halt_wr_i(halt_wr), .halt_wd_i(wr_data_i[HALT_BIT]),
    .halt_o(halt), .xfer_o(xfer), .xfer_live_o(xfer_live)
  );

  rtc_xfer_bank #(.NUM_REGS(NUM_REGS), .NUM_CLK(NUM_CLK), .DW(DW)) u_bank (
    .clk_i, .rst_ni, .tick_i, .inc_i(int_inc_i), .xfer_i(xfer),
    .xfer_live_i(xfer_live), .wr_i, .addr_i(ptr), .wr_data_i,
    .rd_byte_o(rd_byte), .int_o, .ext_o
  );

  always_comb begin
    rd_data_o = rd_byte;
    if (ptr == AW'(HALT_ADDR)) rd_data_o[HALT_BIT] = halt;
  end

  assign ptr_o  = ptr;
  assign halt_o = halt;

  // R4
  aux_read_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !in_clk && !halt && tick_i && !(wr_i)) |=> (ext_o == int_o));
endmodule

// File: tb/rtc_xfer_top_tb_top.sv
`timescale 1ns/1ps
module rtc_xfer_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 0, stop_i = 0, ptr_load_i = 0, wr_i = 0, rd_i = 0;
  logic        tick_i = 0, pfail_i = 0;
  logic [3:0]  ptr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [7:0]  rd_data_o;
  logic [3:0]  ptr_o;
  logic [63:0] int_inc_i, int_o, ext_o;
  logic        halt_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_int [8];
  logic [63:0] snap;

  always #10 clk_i = ~clk_i;

  // stand-in counter chain: byte i advances by i+1
  always_comb begin
    for (int i = 0; i < 8; i++) int_inc_i[i*8 +: 8] = int_o[i*8 +: 8] + 8'(i + 1);
  end

  rtc_xfer_top dut_i (
    .clk_i, .rst_ni, .start_i, .stop_i, .ptr_load_i, .ptr_addr_i, .wr_i,
    .wr_data_i, .rd_i, .rd_data_o, .ptr_o, .tick_i, .pfail_i, .int_inc_i,
    .int_o, .ext_o, .halt_o
  );

  function automatic logic [63:0] pk();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = m_int[i];
    return v;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    if (tick_i) for (int i = 0; i < 8; i++) m_int[i] = m_int[i] + 8'(i + 1);
    @(posedge clk_i); #2;
    start_i = 0; stop_i = 0; ptr_load_i = 0; wr_i = 0; rd_i = 0;
    tick_i = 0; pfail_i = 0;
  endtask

  task automatic load_ptr(input int a);
    ptr_load_i = 1; ptr_addr_i = 4'(a); step();
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_int[i] = '0;
    repeat (2) @(posedge clk_i);
    #5 rst_ni = 1'b1;
    #2;
    // R1
    chk("R1 ptr", 64'(ptr_o), 64'h0);
    chk("R1 ext", ext_o, 64'h0);
    chk("R1 int", int_o, 64'h0);
    chk("R1 halt", 64'(halt_o), 64'h0);

    // R2: free-running ticks move both copies together
    for (int k = 0; k < 3; k++) begin
      tick_i = 1; step();
      chk("R2 int", int_o, pk());
      chk("R2 ext", ext_o, pk());
    end

    // R9: fill 08h..0Fh, pointer wraps to 00h
    load_ptr(8);
    for (int k = 8; k < 16; k++) begin
      wr_i = 1; wr_data_i = 8'hA0 + 8'(k); step();
    end
    chk("R9 wrap", 64'(ptr_o), 64'h0);

    // R3 R4 R5 R10: read start swept over every address, tick in same cycle
    for (int a = 0; a < 16; a++) begin
      stop_i = 1; step();
      load_ptr(a);
      chk("R10 rd_data", 64'(rd_data_o), (a < 8) ? 64'(m_int[a]) : 64'(8'hA0 + 8'(a)));
      snap = ext_o;
      rd_i = 1; tick_i = 1; step();
      chk("R9 inc", 64'(ptr_o), 64'((a + 1) % 16));
      chk("R2 int adv", int_o, pk());
      if (a < 8) begin
        chk("R3 held", ext_o, snap);
        if (a < 7) begin
          step();
          chk("R3 still held", ext_o, snap);
          stop_i = 1; step();
          chk("R4 stop edge", ext_o, snap);
        end
        step();
        chk("R5 catch-up", ext_o, pk());
        step();
        chk("R5 single", ext_o, pk());
      end else begin
        chk("R4 aux read free", ext_o, pk());
      end
    end

    // R6: power fail freezes the user copy
    stop_i = 1; step();
    pfail_i = 1; step();
    chk("R6 halt set", 64'(halt_o), 64'h1);
    load_ptr(12);
    chk("R6 halt bit read", 64'(rd_data_o), 64'hEC);
    snap = ext_o;
    for (int k = 0; k < 3; k++) begin
      tick_i = 1; step();
      chk("R6 ext frozen", ext_o, snap);
    end
    chk("R6 int runs", int_o, pk());
    wr_i = 1; wr_data_i = 8'hAC; step();
    chk("R6 halt clear", 64'(halt_o), 64'h0);
    chk("R6 no xfer yet", ext_o, snap);
    step();
    chk("R6 resume", ext_o, pk());

    // R7: power fail beats a clearing write
    load_ptr(12);
    pfail_i = 1; wr_i = 1; wr_data_i = 8'h00; step();
    chk("R7 halt kept", 64'(halt_o), 64'h1);
    load_ptr(12);
    wr_i = 1; wr_data_i = 8'hAC; step();
    chk("R7 halt cleared", 64'(halt_o), 64'h0);

    // R8: write a clock byte inside a read hold, tick in same cycle
    stop_i = 1; step();
    load_ptr(0);
    rd_i = 1; step();
    load_ptr(3);
    snap = ext_o;
    wr_i = 1; wr_data_i = 8'h5A; tick_i = 1; step();
    m_int[3] = 8'h5A;
    snap[3*8 +: 8] = 8'h5A;
    chk("R8 int", int_o, pk());
    chk("R8 ext", ext_o, snap);
    chk("R9 after wr", 64'(ptr_o), 64'h4);
    stop_i = 1; step();
    chk("R8 held to stop", ext_o, snap);
    step();
    chk("R5 after wr", ext_o, pk());

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule